// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block is a bus-attached parallel I/O controller. It has three 8-bit ports, A, B and C, and a control register. A 2-bit address picks one of the four. Port C is handled as two 4-bit halves, and each half has its own direction. The CPU side is a simple synchronous register bus with address, write data, a write strobe, a read strobe and registered read data. The pin side has three buses per port or half: an input bus for the live pins, an output bus driven from the output latch, and an output-enable.

Software programs the control register to set each port's direction, then writes output data into the latches or reads back the latches or the live pins. A control write whose top bit is clear does not replace the control word. It sets or clears one bit of port C. Only the basic mode is implemented. When a group is programmed for a strobed or bidirectional mode, reads of its port return all ones.

Top module: `ppi_core`

## Requirements
- R1: After reset the control word reads 0x9B, all four output-enables are low, and the A, B and C output buses are 0x00.
- R2: Only address bits [1:0] select the target (0 = port A, 1 = port B, 2 = port C, 3 = control). Higher address bits have no effect.
- R3: In the basic mode, a read of port A or B returns that port's input pins when the port is an input and its output latch when it is an output.
- R4: A control write (address 3, data bit 7 = 1) replaces the control word. Input direction is set as follows: bit 4 for port A, bit 1 for port B, bit 0 for the C low half and bit 3 for the C high half, where 1 means input. Each output-enable is the inverse of its direction bit and changes in the cycle after the write.
- R5: A write to address 3 with data bit 7 = 0 is a bit set/reset command. Data bits [3:1] select a bit of port C and data bit 0 is its new value. The control word and the output-enables are unchanged, and the command applies even when the half is an input.
- R6: A data write to port A, B or C always updates that port's latch, whatever the port's direction. The port's output bus shows the new latch value in the cycle after the write.
- R7: A read of port A returns 0xFF when control bits [6:5] are not 00. A read of port B returns 0xFF when control bit 2 is 1.
- R8: A read of port C returns the C latch, with each half that is configured as an input replaced by its input pins.
- R9: Read data appears on rdata_o in the cycle after a read strobe. It reflects the state before any write in that same cycle, and it holds its value while no read strobe is given.
- R10: A read of address 3 returns the stored control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address; bits [1:0] decoded |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| pa_i | input | 8 | Port A input pins |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A output-enable |
| pb_i | input | 8 | Port B input pins |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B output-enable |
| pcl_i | input | 4 | Port C low half input pins |
| pcl_o | output | 4 | Port C low half output latch |
| pcl_oe_o | output | 1 | Port C low half output-enable |
| pch_i | input | 4 | Port C high half input pins |
| pch_o | output | 4 | Port C high half output latch |
| pch_oe_o | output | 1 | Port C high half output-enable |

## Verification
A corrupted control word is visible at the ports in two places. The output-enables show it one cycle after the write, and a read of address 3 shows it one cycle after the read strobe. A wrong latch value shows up on the port's output bus one cycle after the write. A wrong read selection, such as live pins where the latch is expected or a missing all-ones in a non-basic mode, only appears when that address is read. For that reason the pins are driven with values that differ from the latches, so that the two sources can be told apart in the cycle after each read.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int DW  = 8;
  localparam int NW  = 4;
  localparam int BIW = $clog2(DW);
  localparam int NIW = $clog2(NW);

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } sel_e;

  localparam logic [DW-1:0] CTRL_RST = 8'h9B;

  localparam int CB_CMD   = 7;
  localparam int CB_A_IN  = 4;
  localparam int CB_CH_IN = 3;
  localparam int CB_B_MD  = 2;
  localparam int CB_B_IN  = 1;
  localparam int CB_CL_IN = 0;

  typedef struct packed {
    logic a_in;
    logic b_in;
    logic cl_in;
    logic ch_in;
    logic a_basic;
    logic b_basic;
  } cfg_t;

  function automatic cfg_t decode_cfg(logic [DW-1:0] c);
    cfg_t r;
    r.a_in    = c[CB_A_IN];
    r.b_in    = c[CB_B_IN];
    r.cl_in   = c[CB_CL_IN];
    r.ch_in   = c[CB_CH_IN];
    r.a_basic = (c[6:5] == 2'b00);
    r.b_basic = ~c[CB_B_MD];
    return r;
  endfunction
endpackage

// File: rtl/ppi_ctrl_reg.sv
module ppi_ctrl_reg
  import ppi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     ctrl_o,
  output cfg_t              cfg_o,
  output logic              bsr_o,
  output logic [BIW-1:0]    bsr_idx_o,
  output logic              bsr_val_o
);
  logic [DW-1:0] ctrl_q;
  logic          mode_wr;

  assign mode_wr = wr_i & wdata_i[CB_CMD];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= CTRL_RST;
    else if (mode_wr) ctrl_q <= wdata_i;
  end

  // top bit clear: single-bit command on port C
  assign bsr_o     = wr_i & ~wdata_i[CB_CMD];
  assign bsr_idx_o = wdata_i[BIW:1];
  assign bsr_val_o = wdata_i[0];
  assign ctrl_o    = ctrl_q;
  assign cfg_o     = decode_cfg(ctrl_q);
endmodule

// File: rtl/ppi_port_latch.sv
module ppi_port_latch #(
  parameter int W = 8,
  localparam int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          bit_wr_i,
  input  logic [IW-1:0] bit_idx_i,
  input  logic          bit_val_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (wr_i) begin
      q <= wdata_i;
    end else if (bit_wr_i) begin
      q[bit_idx_i] <= bit_val_i;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
(
  input  sel_e          sel_i,
  input  cfg_t          cfg_i,
  input  logic [DW-1:0] ctrl_i,
  input  logic [DW-1:0] a_q_i,
  input  logic [DW-1:0] b_q_i,
  input  logic [DW-1:0] c_q_i,
  input  logic [DW-1:0] pa_i,
  input  logic [DW-1:0] pb_i,
  input  logic [NW-1:0] pcl_i,
  input  logic [NW-1:0] pch_i,
  output logic [DW-1:0] rd_o
);
  logic [NW-1:0] c_lo, c_hi;

  assign c_lo = cfg_i.cl_in ? pcl_i : c_q_i[NW-1:0];
  assign c_hi = cfg_i.ch_in ? pch_i : c_q_i[DW-1:NW];

  always_comb begin
    unique case (sel_i)
      SEL_A:   rd_o = !cfg_i.a_basic ? '1 : (cfg_i.a_in ? pa_i : a_q_i);
      SEL_B:   rd_o = !cfg_i.b_basic ? '1 : (cfg_i.b_in ? pb_i : b_q_i);
      SEL_C:   rd_o = {c_hi, c_lo};
      default: rd_o = ctrl_i;
    endcase
  end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
  import ppi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pa_i,
  output logic [DW-1:0]     pa_o,
  output logic              pa_oe_o,
  input  logic [DW-1:0]     pb_i,
  output logic [DW-1:0]     pb_o,
  output logic              pb_oe_o,
  input  logic [NW-1:0]     pcl_i,
  output logic [NW-1:0]     pcl_o,
  output logic              pcl_oe_o,
  input  logic [NW-1:0]     pch_i,
  output logic [NW-1:0]     pch_o,
  output logic              pch_oe_o
);
  localparam int NNIB = DW / NW;

  sel_e           sel;
  cfg_t           cfg;
  logic [DW-1:0]  ctrl_q, a_q, b_q, c_q, rd_d, rdata_q;
  logic           bsr;
  logic [BIW-1:0] bsr_idx;
  logic           bsr_val;

  assign sel = sel_e'(addr_i[1:0]);

  generate
    if (ADDR_W > 2) begin : g_hi_addr
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr_i[ADDR_W-1:2];
    end
  endgenerate

  ppi_ctrl_reg u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (we_i && sel == SEL_CTL),
    .wdata_i   (wdata_i),
    .ctrl_o    (ctrl_q),
    .cfg_o     (cfg),
    .bsr_o     (bsr),
    .bsr_idx_o (bsr_idx),
    .bsr_val_o (bsr_val)
  );

  ppi_port_latch #(.W(DW)) u_lat_a (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (we_i && sel == SEL_A),
    .wdata_i   (wdata_i),
    .bit_wr_i  (1'b0),
    .bit_idx_i ('0),
    .bit_val_i (1'b0),
    .q_o       (a_q)
  );

  ppi_port_latch #(.W(DW)) u_lat_b (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (we_i && sel == SEL_B),
    .wdata_i   (wdata_i),
    .bit_wr_i  (1'b0),
    .bit_idx_i ('0),
    .bit_val_i (1'b0),
    .q_o       (b_q)
  );

  // port C: one latch per half, bit command routed by the index's top bit
  for (genvar n = 0; n < NNIB; n++) begin : g_cnib
    logic bit_hit;
    assign bit_hit = bsr && (bsr_idx[BIW-1:NIW] == n);
    ppi_port_latch #(.W(NW)) u_lat_c (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (we_i && sel == SEL_C),
      .wdata_i   (wdata_i[n*NW +: NW]),
      .bit_wr_i  (bit_hit),
      .bit_idx_i (bsr_idx[NIW-1:0]),
      .bit_val_i (bsr_val),
      .q_o       (c_q[n*NW +: NW])
    );
  end

  ppi_read_mux u_rmux (
    .sel_i  (sel),
    .cfg_i  (cfg),
    .ctrl_i (ctrl_q),
    .a_q_i  (a_q),
    .b_q_i  (b_q),
    .c_q_i  (c_q),
    .pa_i   (pa_i),
    .pb_i   (pb_i),
    .pcl_i  (pcl_i),
    .pch_i  (pch_i),
    .rd_o   (rd_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_d;
  end

  assign rdata_o  = rdata_q;
  assign pa_o     = a_q;
  assign pb_o     = b_q;
  assign pcl_o    = c_q[NW-1:0];
  assign pch_o    = c_q[DW-1:NW];
  assign pa_oe_o  = ~cfg.a_in;
  assign pb_oe_o  = ~cfg.b_in;
  assign pcl_oe_o = ~cfg.cl_in;
  assign pch_oe_o = ~cfg.ch_in;
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] sel_i,
  input logic [7:0] wdata_i,
  input logic       we_i,
  input logic       re_i,
  input logic [7:0] rdata_o,
  input logic [7:0] pa_o,
  input logic       pa_oe_o,
  input logic       pb_oe_o,
  input logic [3:0] pcl_o,
  input logic       pcl_oe_o,
  input logic [3:0] pch_o,
  input logic       pch_oe_o,
  input logic [7:0] ctrl_q
);
  logic [7:0] c_out;
  logic [3:0] oe_all;
  logic       mode_wr, bit_cmd;

  assign c_out   = {pch_o, pcl_o};
  assign oe_all  = {pa_oe_o, pb_oe_o, pcl_oe_o, pch_oe_o};
  assign mode_wr = we_i && sel_i == 2'd3 && wdata_i[7];
  assign bit_cmd = we_i && sel_i == 2'd3 && !wdata_i[7];

  AST_OE_FOLLOWS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr |=> (pa_oe_o == !$past(wdata_i[4]) && pb_oe_o == !$past(wdata_i[1]) &&
                 pcl_oe_o == !$past(wdata_i[0]) && pch_oe_o == !$past(wdata_i[3]))); // R4

  AST_BSR_KEEPS_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cmd |=> $stable(oe_all)); // R5

  AST_BSR_SETS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cmd |=> c_out[$past(wdata_i[3:1])] == $past(wdata_i[0])); // R5

  AST_LATCH_A_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 2'd0) |=> pa_o == $past(wdata_i)); // R6

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o)); // R9

  AST_RD_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel_i == 2'd3) |=> rdata_o == $past(ctrl_q)); // R10

  AST_RD_A_NONBASIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel_i == 2'd0 && ctrl_q[6:5] != 2'b00) |=> rdata_o == 8'hFF); // R7
endmodule

bind ppi_core ppi_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (addr_i[1:0]),
  .wdata_i  (wdata_i),
  .we_i     (we_i),
  .re_i     (re_i),
  .rdata_o  (rdata_o),
  .pa_o     (pa_o),
  .pa_oe_o  (pa_oe_o),
  .pb_oe_o  (pb_oe_o),
  .pcl_o    (pcl_o),
  .pcl_oe_o (pcl_oe_o),
  .pch_o    (pch_o),
  .pch_oe_o (pch_oe_o),
  .ctrl_q   (ctrl_q)
);

// File: tb/ppi_core_bench.sv
module ppi_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [7:0]    rdata;
  logic [7:0]    pa_pins = '0, pb_pins = '0;
  logic [3:0]    pcl_pins = '0, pch_pins = '0;
  logic [7:0]    pa_out, pb_out;
  logic [3:0]    pcl_out, pch_out;
  logic          pa_oe, pb_oe, pcl_oe, pch_oe;

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_ctrl, m_a, m_b, m_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  ppi_core #(.ADDR_W(AW)) u_ppi_core (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .we_i(we), .re_i(re), .rdata_o(rdata),
    .pa_i(pa_pins), .pa_o(pa_out), .pa_oe_o(pa_oe),
    .pb_i(pb_pins), .pb_o(pb_out), .pb_oe_o(pb_oe),
    .pcl_i(pcl_pins), .pcl_o(pcl_out), .pcl_oe_o(pcl_oe),
    .pch_i(pch_pins), .pch_o(pch_out), .pch_oe_o(pch_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [1:0] s);
    logic [7:0] v;
    case (s)
      2'd0: v = (m_ctrl[6:5] != 2'b00) ? 8'hFF : (m_ctrl[4] ? pa_pins : m_a);
      2'd1: v = m_ctrl[2] ? 8'hFF : (m_ctrl[1] ? pb_pins : m_b);
      2'd2: v = {m_ctrl[3] ? pch_pins : m_c[7:4], m_ctrl[0] ? pcl_pins : m_c[3:0]};
      default: v = m_ctrl;
    endcase
    return v;
  endfunction

  task automatic check_pins(input string tag);
    chk({tag, " oe"}, {4'h0, pa_oe, pb_oe, pcl_oe, pch_oe},
        {4'h0, ~m_ctrl[4], ~m_ctrl[1], ~m_ctrl[0], ~m_ctrl[3]});
    chk({tag, " latch A"}, pa_out, m_a);
    chk({tag, " latch B"}, pb_out, m_b);
    chk({tag, " latch C"}, {pch_out, pcl_out}, m_c);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    case (a[1:0])
      2'd0: m_a = d;
      2'd1: m_b = d;
      2'd2: m_c = d;
      default: if (d[7]) m_ctrl = d; else m_c[d[3:1]] = d[0];
    endcase
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a);
    logic [7:0] e;
    @(negedge clk);
    addr = a; re = 1'b1;
    e = exp_read(a[1:0]);
    @(negedge clk);
    re = 1'b0;
    chk(tag, rdata, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    m_ctrl = 8'h9B; m_a = 0; m_b = 0; m_c = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check_pins("R1");
    pa_pins = 8'h33; pb_pins = 8'h44; pcl_pins = 4'h6; pch_pins = 4'h9;
    rd("R1 ctrl readback", 8'h03);

    // R6 write to an input port still updates latch; R3 input reads pins
    wr(8'h00, 8'h5A);
    check_pins("R6");
    rd("R3 A input", 8'h00);

    // R4 all outputs
    wr(8'h03, 8'h80);
    check_pins("R4");
    rd("R3 A output", 8'h00);
    rd("R3 B output", 8'h01);

    // R2 upper address bits ignored
    wr(8'hF1, 8'hC3);
    chk("R2 write B", pb_out, 8'hC3);
    rd("R2 read B", 8'h7D);

    // R5 bit set on C bit 5, ctrl unchanged
    wr(8'h03, 8'h0B);
    chk("R5 bit5", {pch_out, pcl_out}, m_c);
    rd("R5 ctrl kept", 8'h03);
    check_pins("R5");

    // R8 low half input only, then both
    wr(8'h02, 8'hA5);
    wr(8'h03, 8'h81);
    rd("R8 C low in", 8'h02);
    wr(8'h03, 8'h89);
    rd("R8 C both in", 8'h02);
    // R5 bit command on an input half changes latch only
    wr(8'h03, 8'h01);
    check_pins("R5 input half");

    // R7 non-basic modes
    wr(8'h03, 8'hA0);
    rd("R7 A strobed", 8'h00);
    wr(8'h03, 8'hC0);
    rd("R7 A bidir", 8'h00);
    wr(8'h03, 8'h84);
    rd("R7 B strobed", 8'h01);
    rd("R10 ctrl", 8'h03);

    // R9 read data holds without read strobe
    begin
      logic [7:0] held;
      held = rdata;
      wr(8'h03, 8'h9B);
      @(negedge clk);
      chk("R9 hold", rdata, held);
    end

    // R9 read and write together: read returns pre-write state
    begin
      logic [7:0] e;
      @(negedge clk);
      addr = 8'h03; wdata = 8'h80; we = 1'b1; re = 1'b1;
      e = m_ctrl;
      @(negedge clk);
      we = 1'b0; re = 1'b0; m_ctrl = 8'h80;
      chk("R9 same-cycle", rdata, e);
    end

    // random mix
    for (int i = 0; i < 600; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      pa_pins = 8'($urandom); pb_pins = 8'($urandom);
      pcl_pins = 4'($urandom); pch_pins = 4'($urandom);
      a = AW'($urandom);
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        wr(a, d);
        check_pins("R4 R5 R6 random");
      end else begin
        rd("R3 R7 R8 R10 random", a);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule